// File: doc/BRIEF.md
# Reduced-Color Palette Lookup Path

This block turns packed 15-bit true-color pixels into three 10-bit converter codes. Every clock it captures a pixel word holding a 5-bit red, a 5-bit green and a 5-bit blue field. It widens each field to an 8-bit table index by placing the field in the low five bits and clearing the upper three. It then reads that channel's own 256-entry, 10-bit look-up table. The three table outputs are registered and drive the red, green and blue converter inputs.

A blanking input, captured with the pixel, replaces all three codes with zero for that pixel. A host-side write port loads any table entry: one channel per write, chosen by a channel select, at any of the 256 indices. Only indices 0 to 31 can be reached by pixels. The upper entries stay loadable but never show on the outputs.

Top module: `pal_lookup_path`

## Requirements
- R1: While `rst_n` is low, and up to the first pixel captured after release, `red_o`, `grn_o` and `blu_o` are all zero.
- R2: A pixel presented on `pix_i` before rising edge k first appears on the outputs after rising edge k+1, and the outputs hold it until edge k+2.
- R3: For a non-blanked pixel, `red_o` equals red table entry `pix_i[14:10]`, `grn_o` equals green table entry `pix_i[9:5]` and `blu_o` equals blue table entry `pix_i[4:0]`.
- R4: The index formed from each field has its three upper bits at zero, so table entries 32 to 255 never reach the outputs, whatever they hold.
- R5: A write with `wr_en_i` high loads `wr_data_i` into entry `wr_idx_i` of the table chosen by `wr_chan_i` (0 red, 1 green, 2 blue) and leaves the other two tables alone; `wr_chan_i` = 3 writes no table.
- R6: When a pixel lookup and a host write address the same entry of the same table on the same edge, the lookup returns the contents held before that write.
- R7: A pixel captured with `blank_i` high gives zero on all three outputs, with the same two-cycle latency as a normal pixel.
- R8: With `wr_en_i` low, the values on `wr_chan_i`, `wr_idx_i` and `wr_data_i` change no table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_i | input | 15 | Packed pixel: red [14:10], green [9:5], blue [4:0] |
| blank_i | input | 1 | Forces this pixel's codes to zero |
| wr_en_i | input | 1 | Host table write strobe |
| wr_chan_i | input | 2 | Target table: 0 red, 1 green, 2 blue, 3 none |
| wr_idx_i | input | 8 | Table entry to write |
| wr_data_i | input | 10 | Value to write |
| red_o | output | 10 | Red converter code |
| grn_o | output | 10 | Green converter code |
| blu_o | output | 10 | Blue converter code |

## Verification
All three tables are first filled with random codes at all 256 indices. Entries 32 to 255 are then overwritten with the complement of the matching low entry. Pixels with equal fields on all channels then show whether an upper index bit leaks into the address, and distinct random fields show whether a channel reads the wrong field or the wrong table. Isolated pixels placed between blanked ones pin down the exact latency. Writes aimed at the entry a pixel is reading in the same cycle separate old-data from new-data behaviour. Writes with the strobe low or the select at 3 show whether a table is written when it should not be. A long random run mixes blanking, writes to all channels and indices, and arbitrary pixels.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int CHANS = 3;

  typedef enum logic [1:0] {
    CH_RED  = 2'd0,
    CH_GRN  = 2'd1,
    CH_BLU  = 2'd2,
    CH_NONE = 2'd3
  } chan_e;
endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pal_field_split.sv
module pal_field_split #(
  parameter int CHANS   = 3,
  parameter int FIELD_W = 5,
  parameter int IDX_W   = 8
) (
  input  logic [CHANS*FIELD_W-1:0]   pix,
  output logic [CHANS-1:0][IDX_W-1:0] idx
);
  localparam int PAD_W = IDX_W - FIELD_W;

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    // channel 0 sits in the most significant field
    always_comb begin
      idx[c] = {{PAD_W{1'b0}}, pix[(CHANS-1-c)*FIELD_W +: FIELD_W]};
    end
  end
endmodule

// File: rtl/pal_lut_bank.sv
module pal_lut_bank #(
  parameter int IDX_W   = 8,
  parameter int CODE_W  = 10,
  parameter int FIELD_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_kill,
  output logic [CODE_W-1:0] code_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [CODE_W-1:0] mem [DEPTH];
  logic [CODE_W-1:0] code_d;
  logic [CODE_W-1:0] code_q;

  // table storage: no reset, written only on strobe
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // read sees pre-write contents on a same-edge collision
  always_comb begin
    code_d = rd_kill ? '0 : mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;

  assert_index_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >> FIELD_W) == '0)
    else $error("lookup index above the pixel window");

  assert_blank_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_kill |=> (code_o == '0))
    else $error("blanked pixel produced a nonzero code");
endmodule

// File: rtl/pal_lookup_path.sv
module pal_lookup_path
  import pal_pkg::*;
#(
  parameter int FIELD_W = 5,
  parameter int IDX_W   = 8,
  parameter int CODE_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3*FIELD_W-1:0]     pix_i,
  input  logic                     blank_i,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_chan_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [CODE_W-1:0]        wr_data_i,
  output logic [CODE_W-1:0]        red_o,
  output logic [CODE_W-1:0]        grn_o,
  output logic [CODE_W-1:0]        blu_o
);
  localparam int PIX_W = CHANS * FIELD_W;

  logic                     srst_n;
  logic [PIX_W-1:0]         pix_d, pix_q;
  logic                     blank_d, blank_q;
  logic [CHANS-1:0][IDX_W-1:0]  idx;
  logic [CHANS-1:0]             chan_we;
  logic [CHANS-1:0][CODE_W-1:0] code;

  pal_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(srst_n)
  );

  // pixel capture stage
  always_comb begin
    pix_d   = pix_i;
    blank_d = blank_i;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pix_q   <= '0;
      blank_q <= 1'b1;
    end else begin
      pix_q   <= pix_d;
      blank_q <= blank_d;
    end
  end

  pal_field_split #(
    .CHANS  (CHANS),
    .FIELD_W(FIELD_W),
    .IDX_W  (IDX_W)
  ) u_split (
    .pix(pix_q),
    .idx(idx)
  );

  for (genvar c = 0; c < CHANS; c++) begin : g_bank
    always_comb begin
      chan_we[c] = wr_en_i && (wr_chan_i == 2'(c));
    end

    pal_lut_bank #(
      .IDX_W  (IDX_W),
      .CODE_W (CODE_W),
      .FIELD_W(FIELD_W)
    ) u_bank (
      .clk    (clk),
      .rst_n  (srst_n),
      .wr_en  (chan_we[c]),
      .wr_idx (wr_idx_i),
      .wr_data(wr_data_i),
      .rd_idx (idx[c]),
      .rd_kill(blank_q),
      .code_o (code[c])
    );
  end

  assign red_o = code[CH_RED];
  assign grn_o = code[CH_GRN];
  assign blu_o = code[CH_BLU];

  assert_single_table_R5: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(chan_we))
    else $error("host write reached more than one table");

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (red_o == '0 && grn_o == '0 && blu_o == '0))
    else $error("outputs not cleared under reset");
endmodule

// File: tb/tb_pal_lookup_path.sv
module tb_pal_lookup_path;
  logic        clk;
  logic        rst_n;
  logic [14:0] pix_i;
  logic        blank_i;
  logic        wr_en_i;
  logic [1:0]  wr_chan_i;
  logic [7:0]  wr_idx_i;
  logic [9:0]  wr_data_i;
  logic [9:0]  red_o, grn_o, blu_o;

  pal_lookup_path dut (
    .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .blank_i(blank_i),
    .wr_en_i(wr_en_i), .wr_chan_i(wr_chan_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [9:0] model [3][256];

  logic [14:0] pend_pix;
  bit          pend_blank;
  bit          pend_valid = 1'b0;
  string       pend_tag;
  logic [9:0]  exp_c [3];
  bit          exp_valid = 1'b0;
  string       exp_tag;

  function automatic logic [9:0] lookup(int ch, logic [14:0] p);
    logic [4:0] f;
    f = p[(2-ch)*5 +: 5];
    return model[ch][{3'b000, f}];
  endfunction

  task automatic compare(string tag, logic [9:0] r, logic [9:0] g, logic [9:0] b);
    checks++;
    if (red_o !== r || grn_o !== g || blu_o !== b) begin
      fails++;
      $display("FAIL %s: got %h %h %h expected %h %h %h", tag,
               red_o, grn_o, blu_o, r, g, b);
    end
  endtask

  // one cycle: check output of pixel from two cycles back, then drive
  task automatic step(logic [14:0] p, bit b, bit we, logic [1:0] ch,
                      logic [7:0] ix, logic [9:0] d, string tag);
    @(negedge clk);
    if (exp_valid) compare(exp_tag, exp_c[0], exp_c[1], exp_c[2]);
    exp_valid = pend_valid;
    exp_tag   = pend_tag;
    for (int c = 0; c < 3; c++)
      exp_c[c] = pend_blank ? 10'd0 : lookup(c, pend_pix);
    pix_i     = p;
    blank_i   = b;
    wr_en_i   = we;
    wr_chan_i = ch;
    wr_idx_i  = ix;
    wr_data_i = d;
    pend_pix   = p;
    pend_blank = b;
    pend_valid = 1'b1;
    pend_tag   = tag;
    if (we && ch != 2'd3) model[ch][ix] = d;
  endtask

  task automatic idle(string tag);
    step(15'd0, 1'b1, 1'b0, 2'd0, 8'd0, 10'd0, tag);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 1 - 1);
    $finish;
  end

  initial begin
    logic [9:0] v;
    void'($urandom(32'd1234));
    rst_n = 1'b0; pix_i = '0; blank_i = 1'b0; wr_en_i = 1'b0;
    wr_chan_i = '0; wr_idx_i = '0; wr_data_i = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare("R1", 10'd0, 10'd0, 10'd0);
    end
    rst_n = 1'b1;
    blank_i = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      compare("R1", 10'd0, 10'd0, 10'd0);
    end

    // load all entries of all tables, outputs blanked (R7)
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 256; i++)
        step(15'd0, 1'b1, 1'b1, 2'(c), 8'(i), 10'($urandom), "R7");
    // make upper entries differ from the low ones (R4)
    for (int c = 0; c < 3; c++)
      for (int f = 0; f < 32; f++)
        for (int k = 1; k < 8; k++)
          step(15'd0, 1'b1, 1'b1, 2'(c), 8'(k*32 + f), ~model[c][f], "R7");
    for (int f = 0; f < 32; f++)
      step({5'(f), 5'(f), 5'(f)}, 1'b0, 1'b0, 2'd0, 8'd0, 10'd0, "R4");

    // R2: isolated pixel between blanked cycles
    idle("R2"); idle("R2");
    step({5'd3, 5'd17, 5'd30}, 1'b0, 1'b0, 2'd0, 8'd0, 10'd0, "R2");
    idle("R2"); idle("R2");

    // R5: green-only write, then select 3
    v = ~model[1][7];
    step(15'd0, 1'b1, 1'b1, 2'd1, 8'd7, v, "R5");
    step({5'd7, 5'd7, 5'd7}, 1'b0, 1'b0, 2'd0, 8'd0, 10'd0, "R5");
    step(15'd0, 1'b1, 1'b1, 2'd3, 8'd7, ~model[0][7], "R5");
    step({5'd7, 5'd7, 5'd7}, 1'b0, 1'b0, 2'd0, 8'd0, 10'd0, "R5");

    // R8: strobe low
    step(15'd0, 1'b1, 1'b0, 2'd0, 8'd9, ~model[0][9], "R8");
    step({5'd9, 5'd9, 5'd9}, 1'b0, 1'b0, 2'd0, 8'd0, 10'd0, "R8");
    idle("R8");

    // R6: write colliding with the lookup on the same edge
    step({5'd5, 5'd12, 5'd20}, 1'b0, 1'b0, 2'd0, 8'd0, 10'd0, "R6");
    step(15'd0, 1'b1, 1'b1, 2'd0, 8'd5, ~model[0][5], "R6");
    step({5'd5, 5'd12, 5'd20}, 1'b0, 1'b0, 2'd0, 8'd0, 10'd0, "R6");
    step(15'd0, 1'b1, 1'b1, 2'd2, 8'd20, ~model[2][20], "R6");
    step({5'd5, 5'd12, 5'd20}, 1'b0, 1'b0, 2'd0, 8'd0, 10'd0, "R6");

    // random mix (R3)
    for (int i = 0; i < 3000; i++)
      step(15'($urandom), ($urandom % 8) == 0, ($urandom % 4) == 0,
           2'($urandom), 8'($urandom), 10'($urandom), "R3");
    idle("R3"); idle("R3"); idle("R3");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule